// File: doc/BRIEF.md
# ADC Test Modulo Compactor

This block compresses the stream of output codes that an analog-to-digital converter produces during a built-in self-test. A test controller first loads a start value, normally the negated expected fault-free sum of all codes. Each time the analog comparator signals a sampling event on `hit`, the block folds the current n-bit code into a residue register modulo L. The build-time parameter `PLUS` selects L: L = 2^N−1 when `PLUS` is 0, or L = 2^N+1 when `PLUS` is 1. With either modulus, a code read in base 2^N carries a weight of +1 or −1 mod L. A corrupted code therefore changes the residue by its own error and is never scaled up by a power of the base.

With L = 2^N−1 every code is added. With L = 2^N+1 the weights alternate between +1 and −1. A constant offset on the codes then cancels across each pair of samples.

When the test sequence ends, `eot` is pulsed. One cycle later `done` rises, and `fault` reports whether the final residue lies outside a programmable tolerance window. The window need not be an exact signature match, and it may wrap around zero. Both flags hold until the next start-value load.

Top module: `adc_residue_compactor`

## Requirements
- R1: After reset, `sig` is 0 and `done` and `fault` are 0.
- R2: When `seed_ld` is high, the next `sig` is `seed` mod L, `done` and `fault` clear, and the weight sequence restarts at +1. This takes priority over `hit` and `eot` in the same cycle.
- R3: In a cycle without `seed_ld` or an accepted hit, `sig` keeps its value.
- R4: With `PLUS`=0 (L = 2^N−1), an accepted hit sets `sig` to (`sig` + `code`) mod L. The all-ones code counts as zero. For N=3, start value 0 and codes 5, 6, 3, 5 give 5.
- R5: With `PLUS`=1 (L = 2^N+1), the odd-numbered accepted hits since the last load add `code` mod L, and the even-numbered ones subtract it mod L.
- R6: With `PLUS`=1, adding the same constant to every code of an even-length sequence leaves the final `sig` unchanged.
- R7: With `PLUS`=0, an accepted hit carrying an all-zero code leaves `sig` unchanged. This lets a trailing zero code end a sequence safely.
- R8: In the cycle after an `eot` seen while `done` is 0, `done` is 1. `fault` is 1 exactly when `sig` is outside the window. The window is `win_lo`..`win_hi` inclusive when `win_lo` ≤ `win_hi`. Otherwise it is the wrapped set `sig` ≥ `win_lo` or `sig` ≤ `win_hi`.
- R9: A hit is accepted only when `done` is 0 and `eot` is low. While `done` is 1, `sig`, `done` and `fault` hold until `seed_ld`.
- R10: `sig` is always less than L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_ld | input | 1 | Load start value and clear verdict |
| seed | input | N+1 | Start value (reduced mod L) |
| hit | input | 1 | Comparator sampling event |
| code | input | N | Converter output code |
| eot | input | 1 | End of test sequence |
| win_lo | input | N+1 | Lower bound of tolerance window |
| win_hi | input | N+1 | Upper bound of tolerance window |
| sig | output | N+1 | Current residue |
| done | output | 1 | Verdict valid |
| fault | output | 1 | Residue outside window |

## Verification
The embedded properties watch, on every cycle, the invariants that involve no arithmetic:
- the residue stays below L;
- the residue holds with no hit;
- a zero code is neutral in the 2^N−1 variant;
- load clears the verdict;
- `done` follows an end-of-test pulse;
- the verdict and residue freeze once `done` is set.

The exact modular values need the bench's sweeps over all start values and codes for both moduli. These include the all-ones code and the alternating signs. The offset cancellation, the wrapped window decisions and the pass/fail outcome of tolerant and offset-faulty code sequences can also only be shown by those scenarios.

// File: rtl/adc_residue_compactor.sv
module adc_residue_compactor #(
  parameter int N    = 3,
  parameter bit PLUS = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         seed_ld,
  input  logic [N:0]   seed,
  input  logic         hit,
  input  logic [N-1:0] code,
  input  logic         eot,
  input  logic [N:0]   win_lo,
  input  logic [N:0]   win_hi,
  output logic [N:0]   sig,
  output logic         done,
  output logic         fault
);
  localparam int RW = N + 1;
  localparam int LI = PLUS ? (2**N) + 1 : (2**N) - 1;
  localparam logic [RW:0] L = LI[RW:0];

  logic          neg;
  logic          accept;
  logic [RW:0]   cz, cr, ext, t, nxt, sd;
  logic          in_win;

  assign accept = hit && !done && !eot;
  assign cz     = {2'b00, code};
  assign cr     = (cz >= L) ? cz - L : cz;
  assign ext    = {1'b0, sig};
  assign t      = neg ? ext + L - cr : ext + cr;
  assign nxt    = (t >= L) ? t - L : t;
  assign sd     = {1'b0, seed} % L;

  assign in_win = (win_lo <= win_hi) ? (sig >= win_lo && sig <= win_hi)
                                     : (sig >= win_lo || sig <= win_hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sig   <= '0;
      neg   <= 1'b0;
      done  <= 1'b0;
      fault <= 1'b0;
    end else if (seed_ld) begin
      sig   <= sd[RW-1:0];
      neg   <= 1'b0;
      done  <= 1'b0;
      fault <= 1'b0;
    end else begin
      if (accept) begin
        sig <= nxt[RW-1:0];
        neg <= PLUS ? ~neg : 1'b0;
      end
      if (eot && !done) begin
        done  <= 1'b1;
        fault <= !in_win;
      end
    end
  end

  p_below_mod_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, sig} < L));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_ld && !hit) |=> $stable(sig));

  p_zero_neutral_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!PLUS && hit && !done && !eot && !seed_ld && code == '0) |=> $stable(sig));

  p_load_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seed_ld |=> (!done && !fault));

  p_verdict_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eot && !done && !seed_ld) |=> done);

  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !seed_ld) |=> (done && $stable(sig) && $stable(fault)));
endmodule

// File: tb/adc_residue_compactor_bench.sv
`timescale 1ns/1ps
module adc_residue_compactor_bench;
  localparam int N = 3;
  localparam int LA = 7;
  localparam int LB = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seed_ld = 1'b0, hit = 1'b0, eot = 1'b0;
  logic [N:0] seed = '0, win_lo = '0, win_hi = '0;
  logic [N-1:0] code = '0;
  logic [N:0] sig_a, sig_b;
  logic done_a, done_b, fault_a, fault_b;

  always #2 clk = ~clk;

  adc_residue_compactor #(.N(N), .PLUS(1'b0)) u_adc_residue_compactor (
    .clk(clk), .rst_n(rst_n), .seed_ld(seed_ld), .seed(seed), .hit(hit),
    .code(code), .eot(eot), .win_lo(win_lo), .win_hi(win_hi),
    .sig(sig_a), .done(done_a), .fault(fault_a));

  adc_residue_compactor #(.N(N), .PLUS(1'b1)) u_adc_residue_compactor_alt (
    .clk(clk), .rst_n(rst_n), .seed_ld(seed_ld), .seed(seed), .hit(hit),
    .code(code), .eot(eot), .win_lo(win_lo), .win_hi(win_hi),
    .sig(sig_b), .done(done_b), .fault(fault_b));

  int errs = 0, checks = 0;
  int ma = 0, mb = 0, fa = 0, fb = 0, dn = 0, ng = 0;
  bit finished = 0;

  function automatic int inwin(int r, int lo, int hi);
    if (lo <= hi) return (r >= lo && r <= hi) ? 1 : 0;
    return (r >= lo || r <= hi) ? 1 : 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit sl, int sv, bit h, int c, bit e);
    seed_ld = sl; seed = sv[N:0]; hit = h; code = c[N-1:0]; eot = e;
    @(negedge clk);
    seed_ld = 0; hit = 0; eot = 0;
    if (sl) begin
      ma = sv % LA; mb = sv % LB; ng = 0; dn = 0; fa = 0; fb = 0;
    end else begin
      if (h && !dn && !e) begin
        ma = (ma + c) % LA;
        mb = ng ? (mb + LB - c) % LB : (mb + c) % LB;
        ng = 1 - ng;
      end
      if (e && !dn) begin
        dn = 1;
        fa = 1 - inwin(ma, int'(win_lo), int'(win_hi));
        fb = 1 - inwin(mb, int'(win_lo), int'(win_hi));
      end
    end
  endtask

  task automatic chk_all(string tag);
    chk({tag, " sigA"}, int'(sig_a), ma);
    chk({tag, " sigB"}, int'(sig_b), mb);
    chk({tag, " doneA"}, int'(done_a), dn);
    chk({tag, " faultA"}, int'(fault_a), fa);
    chk({tag, " faultB"}, int'(fault_b), fb);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int ref_b;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 sig", int'(sig_a), 0);
    chk("R1 done", int'(done_a), 0);
    chk("R1 fault", int'(fault_b), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R4 R5 R10: every start value and code, both moduli
    for (int s = 0; s < 16; s++)
      for (int c = 0; c < 8; c++) begin
        step(1, s, 0, 0, 0);
        chk("R2 load A", int'(sig_a), s % LA);
        chk("R2 load B", int'(sig_b), s % LB);
        step(0, 0, 1, c, 0);
        chk("R4 add A", int'(sig_a), (s % LA + c) % LA);
        chk("R5 first B", int'(sig_b), (s % LB + c) % LB);
        chk("R10 range A", int'(sig_a < LA), 1);
      end

    // R5 second hit subtracts
    for (int c1 = 0; c1 < 8; c1++)
      for (int c2 = 0; c2 < 8; c2++) begin
        step(1, 0, 0, 0, 0);
        step(0, 0, 1, c1, 0);
        step(0, 0, 1, c2, 0);
        chk("R5 alt B", int'(sig_b), (c1 - c2 + LB) % LB);
      end

    // R4 worked example 5,6,3,5 -> 5
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 5, 0); step(0, 0, 1, 6, 0);
    step(0, 0, 1, 3, 0); step(0, 0, 1, 5, 0);
    chk("R4 example", int'(sig_a), 5);

    // R7 zero code neutral; R3 idle hold
    step(1, 4, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    chk("R7 zero", int'(sig_a), 4);
    step(0, 0, 0, 5, 0);
    chk("R3 idle A", int'(sig_a), 4);
    chk("R3 idle B", int'(sig_b), mb);

    // R6 offset cancels
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 2, 0); step(0, 0, 1, 3, 0);
    step(0, 0, 1, 4, 0); step(0, 0, 1, 5, 0);
    ref_b = int'(sig_b);
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 3, 0); step(0, 0, 1, 4, 0);
    step(0, 0, 1, 5, 0); step(0, 0, 1, 6, 0);
    chk("R6 offset", int'(sig_b), ref_b);
    chk("R6 value", int'(sig_b), 7);

    // R8 window sweep incl. wrap
    for (int lo = 0; lo < 9; lo++)
      for (int hi = 0; hi < 9; hi++) begin
        step(1, 3 + lo % 4, 0, 0, 0);
        win_lo = lo[N:0]; win_hi = hi[N:0];
        step(0, 0, 0, 0, 1);
        chk("R8 doneB", int'(done_b), 1);
        chk_all("R8 window");
      end

    // R9 hits ignored after and during eot; held until load
    step(1, 2, 0, 0, 0);
    win_lo = 0; win_hi = 0;
    step(0, 0, 1, 5, 1);
    chk_all("R9 hit at eot");
    step(0, 0, 1, 3, 0);
    step(0, 0, 0, 0, 1);
    chk_all("R9 frozen");
    step(1, 1, 1, 6, 1);
    chk_all("R2 priority");

    // R8 pass/fail scenarios: nominal 2,3,4,5 sum 14, window +-1 (wrap)
    win_lo = 6; win_hi = 1;
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 3, 0); step(0, 0, 1, 3, 0);
    step(0, 0, 1, 4, 0); step(0, 0, 1, 5, 0);
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 1);
    chk("R8 tolerant pass", int'(fault_a), 0);
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 2, 0); step(0, 0, 1, 2, 0);
    step(0, 0, 1, 4, 0); step(0, 0, 1, 5, 0);
    step(0, 0, 0, 0, 1);
    chk("R8 low pass", int'(fault_a), 0);
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 1, 0); step(0, 0, 1, 2, 0);
    step(0, 0, 1, 5, 0); step(0, 0, 1, 4, 0);
    step(0, 0, 0, 0, 1);
    chk("R8 offset fault", int'(fault_a), 1);
    chk("R8 offset done", int'(done_a), 1);
    // seeded example: nominal 5,6,3,5 sum 19, negated seed 2, exact window
    win_lo = 0; win_hi = 0;
    step(1, 2, 0, 0, 0);
    step(0, 0, 1, 5, 0); step(0, 0, 1, 6, 0);
    step(0, 0, 1, 3, 0); step(0, 0, 1, 5, 0);
    step(0, 0, 0, 0, 1);
    chk("R8 seeded pass", int'(fault_a), 0);
    chk_all("R8 seeded");

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule